// File: doc/BRIEF.md
# Ultra DMA Burst CRC Checker (Device Side)

This block sits on the device side of an Ultra DMA link. It checks the host's CRC at the end of each burst and keeps a sticky record of errors across one command. While a burst is open it runs a 16-bit CRC over every data word the device's data path hands it. When the host negates its DMA acknowledge, the block takes the host's CRC word from the data bus and compares it one cycle later with its own result for that burst.

Only the earliest miscompare of a command is kept. The block stores the index of that burst within the command, the host's word and the device's value. A command-start pulse clears this record. A command-end pulse publishes the outcome on a report port. The block also controls the output enable of the device's data strobe pin, so that the pin is released a fixed number of clock cycles after the acknowledge goes away.

The acknowledge input is asynchronous and passes through a two-flop synchronizer. The data words and the bus sample are taken as already being in the block's clock domain.

Top module: `udma_crc_chk`

## Requirements
- R1: The CRC uses polynomial 0x1021 (x^16+x^12+x^5+1). Each word with `dword_vld` high updates it bit by bit, bit 15 first, shifting left, with the feedback taken as crc[15] XOR the data bit.
- R2: The CRC is loaded with 0x4ABA on the clock after the synchronizer first sees `dmack_n` low, so words that arrive while `dmack_n` is high have no effect on the next burst's result.
- R3: On the clock after the synchronizer first sees `dmack_n` high, `dbus` is captured as the host CRC. One cycle later it is compared with the device CRC. A mismatch raises `err_flag` and loads `err_host_crc` and `err_dev_crc`.
- R4: A burst whose host CRC equals the device CRC leaves `err_flag` low.
- R5: Only the first mismatch of a command is recorded. Later mismatches leave `err_flag`, `err_burst`, `err_host_crc` and `err_dev_crc` unchanged.
- R6: `err_burst` is the 0-based number of acknowledge negations since `cmd_start` at the time of the failing burst. The count saturates at 2^IDX_W-1.
- R7: `cmd_start` clears the error record and the burst count.
- R8: A `cmd_end` pulse gives a one-cycle `rpt_vld` on the next clock. On that clock `rpt_err` and `rpt_burst` take the error flag and burst index, and they hold them until the next report.
- R9: `dstrobe_oe` rises after the acknowledge is asserted. It falls on exactly the T_IORDYZ-th rising clock edge after `dmack_n` goes high, counting the first edge that sees it high.
- R10: After reset, `dstrobe_oe`, `err_flag`, `err_burst` and `rpt_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Pulse: a new command begins |
| cmd_end | input | 1 | Pulse: the command is complete; report its outcome |
| dmack_n | input | 1 | Host DMA acknowledge, active low, asynchronous |
| dbus | input | 16 | Data bus: data words, and the host CRC at the end of a burst |
| dword_vld | input | 1 | `dbus` holds a data word to add to the CRC |
| dstrobe_oe | output | 1 | Output enable for the device data strobe pin |
| err_flag | output | 1 | Sticky first-error flag for the current command |
| err_burst | output | IDX_W | Burst index of the first error |
| err_host_crc | output | 16 | Host CRC of the first failing burst |
| err_dev_crc | output | 16 | Device CRC of the first failing burst |
| rpt_vld | output | 1 | One-cycle report strobe |
| rpt_err | output | 1 | Reported error status |
| rpt_burst | output | IDX_W | Reported burst index |

## Verification
The bench builds the block with IDX_W=3 and T_IORDYZ=5. The narrow index lets a single nine-burst command drive the burst counter into saturation. The short release time leaves a two-cycle hold counter, so the exact cycle on which `dstrobe_oe` falls can be checked directly. Random commands with random word counts, random data and randomly corrupted host CRC words test the first-error-only rule. Garbage words sent between bursts test the reseed.

// File: rtl/udma_crc_pkg.sv
package udma_crc_pkg;
  localparam int unsigned WORD_W = 16;
  localparam logic [WORD_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [WORD_W-1:0] CRC_SEED = 16'h4ABA;

  typedef logic [WORD_W-1:0] word_t;

  // One whole-word CRC step, data bit 15 first.
  function automatic word_t crc_word_step(word_t cur, word_t din);
    word_t acc;
    logic  fb;
    acc = cur;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb  = acc[WORD_W-1] ^ din[i];
      acc = {acc[WORD_W-2:0], 1'b0};
      if (fb) acc = acc ^ CRC_POLY;
    end
    return acc;
  endfunction
endpackage

// File: rtl/udma_dmack_sync.sv
module udma_dmack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dmack_n_in,
  output logic ack_on,
  output logic ack_rise,
  output logic ack_drop
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              hi_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], dmack_n_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign hi_now   = sync_q[STAGES-1];
  assign ack_on   = ~hi_now;
  assign ack_rise = ~hi_now & last_q;
  assign ack_drop = hi_now & ~last_q;

  p_edges_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_rise && ack_drop));
  p_drop_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_drop |=> !ack_drop);
endmodule

// File: rtl/udma_crc16.sv
module udma_crc16
  import udma_crc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  reseed,
  input  logic  upd,
  input  word_t word,
  output word_t crc
);
  word_t crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (reseed)   crc_d = CRC_SEED;
    else if (upd) crc_d = crc_word_step(crc_q, word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             crc_q <= CRC_SEED;
    else if (reseed || upd) crc_q <= crc_d;
  end

  assign crc = crc_q;

  p_reseed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |=> crc == CRC_SEED);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!reseed && !upd) |=> $stable(crc));
endmodule

// File: rtl/udma_first_err.sv
module udma_first_err
  import udma_crc_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_end,
  input  logic             ack_drop,
  input  word_t            bus_word,
  input  word_t            dev_crc,
  output logic             err_flag,
  output logic [IDX_W-1:0] err_idx,
  output word_t            err_host,
  output word_t            err_dev,
  output logic             rpt_vld,
  output logic             rpt_err,
  output logic [IDX_W-1:0] rpt_idx
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] cnt_q, cnt_d, cap_idx_q, cap_idx_d;
  word_t            cap_host_q, cap_host_d, cap_dev_q, cap_dev_d;
  logic             cmp_q, cmp_d;
  logic             err_q, err_d;
  logic [IDX_W-1:0] eidx_q, eidx_d, ridx_q, ridx_d;
  word_t            ehost_q, ehost_d, edev_q, edev_d;
  logic             rv_q, rv_d, rerr_q, rerr_d;

  always_comb begin
    cnt_d      = cnt_q;
    cap_idx_d  = cap_idx_q;
    cap_host_d = cap_host_q;
    cap_dev_d  = cap_dev_q;
    cmp_d      = 1'b0;
    err_d      = err_q;
    eidx_d     = eidx_q;
    ehost_d    = ehost_q;
    edev_d     = edev_q;
    rv_d       = 1'b0;
    rerr_d     = rerr_q;
    ridx_d     = ridx_q;
    if (ack_drop) begin
      cap_host_d = bus_word;
      cap_dev_d  = dev_crc;
      cap_idx_d  = cnt_q;
      cmp_d      = 1'b1;
      if (cnt_q != IDX_MAX) cnt_d = cnt_q + 1'b1;
    end
    if (cmp_q && !err_q && (cap_host_q != cap_dev_q)) begin
      err_d   = 1'b1;
      eidx_d  = cap_idx_q;
      ehost_d = cap_host_q;
      edev_d  = cap_dev_q;
    end
    if (cmd_end) begin
      rv_d   = 1'b1;
      rerr_d = err_q;
      ridx_d = eidx_q;
    end
    if (cmd_start) begin
      cnt_d   = '0;
      cmp_d   = 1'b0;
      err_d   = 1'b0;
      eidx_d  = '0;
      ehost_d = '0;
      edev_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      cap_idx_q  <= '0;
      cap_host_q <= '0;
      cap_dev_q  <= '0;
      cmp_q      <= 1'b0;
      err_q      <= 1'b0;
      eidx_q     <= '0;
      ehost_q    <= '0;
      edev_q     <= '0;
      rv_q       <= 1'b0;
      rerr_q     <= 1'b0;
      ridx_q     <= '0;
    end else begin
      cnt_q      <= cnt_d;
      cap_idx_q  <= cap_idx_d;
      cap_host_q <= cap_host_d;
      cap_dev_q  <= cap_dev_d;
      cmp_q      <= cmp_d;
      err_q      <= err_d;
      eidx_q     <= eidx_d;
      ehost_q    <= ehost_d;
      edev_q     <= edev_d;
      rv_q       <= rv_d;
      rerr_q     <= rerr_d;
      ridx_q     <= ridx_d;
    end
  end

  assign err_flag = err_q;
  assign err_idx  = eidx_q;
  assign err_host = ehost_q;
  assign err_dev  = edev_q;
  assign rpt_vld  = rv_q;
  assign rpt_err  = rerr_q;
  assign rpt_idx  = ridx_q;

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !cmd_start) |=> err_flag && $stable(err_idx) && $stable(err_host) && $stable(err_dev));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !err_flag && cnt_q == '0);
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_drop && !cmd_start && cnt_q != IDX_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == IDX_MAX && !cmd_start) |=> cnt_q == IDX_MAX);
  p_err_differs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> err_host != err_dev);
  p_report_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_end |=> rpt_vld && rpt_err == $past(err_flag) && rpt_idx == $past(err_idx));
endmodule

// File: rtl/udma_strobe_rel.sv
module udma_strobe_rel #(
  parameter int unsigned T_IORDYZ = 6,
  parameter int unsigned SYNC_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_rise,
  input  logic ack_drop,
  output logic oe
);
  localparam int unsigned HOLD = T_IORDYZ - SYNC_LAT;

  logic oe_q, oe_d;

  generate
    if (HOLD == 0) begin : g_direct
      always_comb begin
        oe_d = oe_q;
        if (ack_rise)      oe_d = 1'b1;
        else if (ack_drop) oe_d = 1'b0;
      end
    end else begin : g_count
      localparam int unsigned CW = $clog2(HOLD + 1);
      localparam logic [CW-1:0] HOLD_V = CW'(HOLD);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          pend_q, pend_d;

      always_comb begin
        oe_d   = oe_q;
        cnt_d  = cnt_q;
        pend_d = pend_q;
        if (ack_rise) begin
          oe_d   = 1'b1;
          pend_d = 1'b0;
        end else if (ack_drop) begin
          pend_d = 1'b1;
          cnt_d  = HOLD_V;
        end else if (pend_q) begin
          if (cnt_q == CW'(1)) begin
            oe_d   = 1'b0;
            pend_d = 1'b0;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q  <= '0;
          pend_q <= 1'b0;
        end else begin
          cnt_q  <= cnt_d;
          pend_q <= pend_d;
        end
      end

      p_pend_keeps_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> oe_q);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= oe_d;
  end

  assign oe = oe_q;

  p_oe_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rise |=> oe);
endmodule

// File: rtl/udma_crc_chk.sv
module udma_crc_chk
  import udma_crc_pkg::*;
#(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned T_IORDYZ = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_end,
  input  logic             dmack_n,
  input  logic [15:0]      dbus,
  input  logic             dword_vld,
  output logic             dstrobe_oe,
  output logic             err_flag,
  output logic [IDX_W-1:0] err_burst,
  output logic [15:0]      err_host_crc,
  output logic [15:0]      err_dev_crc,
  output logic             rpt_vld,
  output logic             rpt_err,
  output logic [IDX_W-1:0] rpt_burst
);
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned DROP_LAT    = SYNC_STAGES + 1;

  logic  rst_meta_q, rst_sync_q;
  logic  ack_on, ack_rise, ack_drop;
  word_t crc_now;

  // Reset asserts at once, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  udma_dmack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .dmack_n_in (dmack_n),
    .ack_on     (ack_on),
    .ack_rise   (ack_rise),
    .ack_drop   (ack_drop)
  );

  udma_crc16 u_crc (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .reseed (ack_rise),
    .upd    (dword_vld),
    .word   (dbus),
    .crc    (crc_now)
  );

  udma_first_err #(.IDX_W(IDX_W)) u_err (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .cmd_start (cmd_start),
    .cmd_end   (cmd_end),
    .ack_drop  (ack_drop),
    .bus_word  (dbus),
    .dev_crc   (crc_now),
    .err_flag  (err_flag),
    .err_idx   (err_burst),
    .err_host  (err_host_crc),
    .err_dev   (err_dev_crc),
    .rpt_vld   (rpt_vld),
    .rpt_err   (rpt_err),
    .rpt_idx   (rpt_burst)
  );

  udma_strobe_rel #(.T_IORDYZ(T_IORDYZ), .SYNC_LAT(DROP_LAT)) u_rel (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .ack_rise (ack_rise),
    .ack_drop (ack_drop),
    .oe       (dstrobe_oe)
  );

  initial begin
    if (T_IORDYZ < DROP_LAT) $error("T_IORDYZ below synchronizer latency");
    if (IDX_W < 1)           $error("IDX_W must be at least 1");
  end

  p_oe_reset_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!ack_on && !dstrobe_oe) |=> !dstrobe_oe);
endmodule

// File: tb/udma_crc_chk_test.sv
module udma_crc_chk_test;
  localparam int unsigned IDX_W = 3;
  localparam int unsigned TZ    = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_start = 1'b0, cmd_end = 1'b0, dmack_n = 1'b1, dword_vld = 1'b0;
  logic [15:0]      dbus = '0;
  logic             dstrobe_oe, err_flag, rpt_vld, rpt_err;
  logic [IDX_W-1:0] err_burst, rpt_burst;
  logic [15:0]      err_host_crc, err_dev_crc;

  int unsigned n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  logic             e_err;
  logic [IDX_W-1:0] e_idx, bno;
  logic [15:0]      e_host, e_dev;

  always #5 clk = ~clk;

  udma_crc_chk #(.IDX_W(IDX_W), .T_IORDYZ(TZ)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_end(cmd_end),
    .dmack_n(dmack_n), .dbus(dbus), .dword_vld(dword_vld),
    .dstrobe_oe(dstrobe_oe), .err_flag(err_flag), .err_burst(err_burst),
    .err_host_crc(err_host_crc), .err_dev_crc(err_dev_crc),
    .rpt_vld(rpt_vld), .rpt_err(rpt_err), .rpt_burst(rpt_burst)
  );

  // Reference CRC: poly 0x1021, MSB first.
  function automatic logic [15:0] ref_crc(logic [15:0] c, logic [15:0] w);
    logic [15:0] r = c;
    for (int k = 0; k < 16; k++) begin
      logic b = r[15] ^ w[15-k];
      r = (r << 1) ^ (b ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic new_cmd();
    cmd_start = 1'b1; @(negedge clk); cmd_start = 1'b0;
    e_err = 1'b0; e_idx = '0; e_host = '0; e_dev = '0; bno = '0;
  endtask

  // One burst of n words; bad selects a corrupted host CRC.
  task automatic burst(int n, bit bad);
    logic [15:0] c = 16'h4ABA;
    logic [15:0] h;
    dmack_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      dbus = 16'($urandom); dword_vld = 1'b1;
      c = ref_crc(c, dbus);
      @(negedge clk);
    end
    dword_vld = 1'b0;
    h = bad ? (c ^ 16'(($urandom % 16'hFFFF) + 1)) : c;
    dbus = h; dmack_n = 1'b1;
    repeat (7) @(negedge clk);
    if (bad && !e_err) begin
      e_err = 1'b1; e_idx = bno; e_host = h; e_dev = c;
    end
    if (bno != {IDX_W{1'b1}}) bno = bno + 1'b1;
  endtask

  task automatic end_cmd(string req);
    cmd_end = 1'b1; @(negedge clk); cmd_end = 1'b0;
    chk({req, " R8 rpt_vld"}, rpt_vld, 1);
    chk({req, " R8 rpt_err"}, rpt_err, e_err);
    if (e_err) chk({req, " R6 rpt_burst"}, rpt_burst, e_idx);
    chk({req, " R3 err_flag"}, err_flag, e_err);
    if (e_err) begin
      chk({req, " R5 err_burst"}, err_burst, e_idx);
      chk({req, " R3 err_host_crc"}, err_host_crc, e_host);
      chk({req, " R1 err_dev_crc"}, err_dev_crc, e_dev);
    end
    @(negedge clk);
    chk({req, " R8 rpt_vld pulse"}, rpt_vld, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R10 oe", dstrobe_oe, 0);
    chk("R10 err_flag", err_flag, 0);
    chk("R10 err_burst", err_burst, 0);
    chk("R10 rpt_vld", rpt_vld, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    new_cmd();

    // R9: release timing
    dmack_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 oe asserted", dstrobe_oe, 1);
    dmack_n = 1'b1;
    repeat (TZ - 1) @(negedge clk);
    chk("R9 oe still held", dstrobe_oe, 1);
    @(negedge clk);
    chk("R9 oe released", dstrobe_oe, 0);
    repeat (4) @(negedge clk);
    new_cmd();

    // R4: good burst; R2: garbage words before the burst
    for (int i = 0; i < 5; i++) begin
      dbus = 16'($urandom); dword_vld = 1'b1; @(negedge clk);
    end
    dword_vld = 1'b0;
    burst(3, 1'b0);
    chk("R2/R4 no error after reseed", err_flag, 0);
    burst(2, 1'b1);
    chk("R3 mismatch flagged", err_flag, 1);
    burst(2, 1'b1);
    end_cmd("R5 second miss ignored");

    // R7: clear
    new_cmd();
    chk("R7 cleared flag", err_flag, 0);
    burst(1, 1'b1);
    end_cmd("R7 index restarts");

    // R6: saturation after nine bursts
    new_cmd();
    for (int b = 0; b < 9; b++) burst(1, b == 8);
    end_cmd("R6 saturated index");
    chk("R6 sat value", err_burst, 7);

    // Random commands
    for (int c = 0; c < 30; c++) begin
      int nb = 1 + int'($urandom % 4);
      new_cmd();
      for (int b = 0; b < nb; b++)
        burst(1 + int'($urandom % 8), ($urandom % 3) == 0);
      end_cmd("R5 random");
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule